// File: doc/BRIEF.md
# Chaotic Keystream Byte Generator

This block hands out one pseudo-random byte each time it is asked. Behind each request it advances a two-dimensional quadratic chaotic map by one step. The map uses signed fixed-point arithmetic. The block then turns the new first state variable into a byte. To do that it scales the magnitude of the variable by ten million and reduces the result modulo 255. The reduction uses an explicit divide, floor, multiply-back and subtract. A companion stage can XOR the byte with a data byte to mask or unmask it, and the same key gives the same byte stream on both sides.

The two initial map states form the key. Loading them restarts the stream. After a load, the first request returns the byte of the first map iteration. A request is accepted only while the block is idle. The answer appears a fixed 36 cycles later, together with a one-cycle done pulse.

The controller has six states. IDLE waits; on an accepted request it updates the map registers and moves to MAG. MAG captures the magnitude of the state, widened to the conversion format, and moves to SCALE. SCALE captures the scaled integer, loads the divider and moves to DIV. DIV runs one quotient bit per cycle and moves to MULB on the last bit. MULB forms quotient × 255 and moves to SUB. SUB writes the byte, pulses done and returns to IDLE. A key load sends every state straight back to IDLE.

Top module: `kmap_keystream`

## Requirements
- R1: After reset, done is 0, byte_out is 0 and both map states are 0. The first request after reset therefore returns 175.
- R2: Map states are signed 24-bit words with 20 fractional bits. One step computes x' = 1 − a·(x·x) + y and y' = b·x. Here a = 1468006 and b = 314572 in the same format. Every product is truncated toward minus infinity by a 20-bit arithmetic shift, and the sums wrap at 24 bits.
- R3: The output byte is S mod 255, so it lies in 0..254. S is computed in three steps. First the new x is widened to a 32-bit word with 23 fractional bits by a left shift of 3. Then its magnitude is taken, so negative states use their absolute value. Finally S = floor(|x| · 10^7 / 2^23).
- R4: done is high for exactly one cycle. It rises 36 clock edges after the edge that accepts a request. byte_out changes only on that edge and holds its value otherwise.
- R5: A request raised while a conversion is in progress is ignored. It does not move the done edge, add an iteration or produce a second done.
- R6: A key load copies key_x and key_y into the map states. It aborts any conversion in progress, and no done follows. The next request returns the byte of the first iteration from the new key.
- R7: A one-LSB change in key_x gives a byte sequence that differs from the original.
- R8: Each accepted request advances the map by exactly one step. Consecutive requests return consecutive iterates.
- R9: When key_load and start are high in the same cycle, the load wins and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Load new initial states (key) and restart |
| key_x | input | 24 | Initial first state, signed Q4.20 |
| key_y | input | 24 | Initial second state, signed Q4.20 |
| start | input | 1 | Request one byte; acted on only when idle |
| done | output | 1 | One-cycle pulse marking a new byte |
| byte_out | output | 8 | Keystream byte, 0..254 |

## Verification
The bench first uses a short table of hand-derived bytes from the all-zero key: 175, then 66 from a negative state, then 31. A design that truncated toward zero, skipped the magnitude step or got the Q23 shift wrong would miss these bytes. Every done edge is timed against 36 cycles, which catches an extra or missing stage or a divider count that is off by one. Requests raised mid-conversion, key loads that abort a conversion, and a load coinciding with a request are all probed. A design that restarted, double-stepped or let the request win would then give a wrong byte or an unexpected done. Last, a one-LSB key change is checked, against a reference model, for a differing stream.

// File: rtl/kmap_pkg.sv
package kmap_pkg;
    // Controller states, in the order a request walks through them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MAG   = 3'd1,
        ST_SCALE = 3'd2,
        ST_DIV   = 3'd3,
        ST_MULB  = 3'd4,
        ST_SUB   = 3'd5
    } kmap_state_e;

    // Default fixed-point map constants (Q4.20): a = 1.4, b = 0.3, truncated.
    localparam int unsigned KMAP_A_DEF = 1468006;
    localparam int unsigned KMAP_B_DEF = 314572;
endpackage

// File: rtl/kmap_step.sv
// One combinational step of the quadratic map in signed fixed point.
module kmap_step #(
    parameter int W = 24,
    parameter int F = 20,
    parameter int unsigned A_FX = kmap_pkg::KMAP_A_DEF,
    parameter int unsigned B_FX = kmap_pkg::KMAP_B_DEF
) (
    input  logic signed [W-1:0] x_cur,
    input  logic signed [W-1:0] y_cur,
    output logic signed [W-1:0] x_nxt,
    output logic signed [W-1:0] y_nxt
);
    localparam int PW = 2 * W;
    localparam logic signed [W-1:0] ONE_C = W'(1) << F;
    localparam logic signed [W-1:0] A_C   = W'(A_FX);
    localparam logic signed [W-1:0] B_C   = W'(B_FX);

    logic signed [PW-1:0] sq_p;
    logic signed [PW-1:0] ax_p;
    logic signed [PW-1:0] bx_p;
    logic signed [W-1:0]  sq_t;
    logic signed [W-1:0]  ax_t;

    always_comb begin
        sq_p  = PW'(x_cur) * PW'(x_cur);
        // Taking bits [F+W-1:F] is an arithmetic shift by F (floor), then wrap.
        sq_t  = sq_p[F+W-1:F];
        ax_p  = PW'(A_C) * PW'(sq_t);
        ax_t  = ax_p[F+W-1:F];
        bx_p  = PW'(B_C) * PW'(x_cur);
        x_nxt = ONE_C - ax_t + y_cur;
        y_nxt = bx_p[F+W-1:F];
    end
endmodule

// File: rtl/kmap_scale.sv
// Magnitude capture and fixed-point scaling of the map state.
module kmap_scale #(
    parameter int MAP_W   = 24,
    parameter int MAP_F   = 20,
    parameter int CONV_W  = 32,
    parameter int CONV_F  = 23,
    parameter int unsigned SCALE_K = 10_000_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [MAP_W-1:0] x_in,
    input  logic                    cap_mag,
    input  logic                    cap_scale,
    output logic [CONV_W-1:0]       scaled_d,
    output logic [CONV_W-1:0]       scaled_q
);
    localparam int SH     = CONV_F - MAP_F;
    localparam int K_W    = $clog2(SCALE_K + 1);
    localparam int PROD_W = CONV_W + K_W;

    logic signed [CONV_W-1:0] x_ext;
    logic [CONV_W-1:0]        mag_d;
    logic [CONV_W-1:0]        mag_q;
    logic [PROD_W-1:0]        prod;

    always_comb begin
        x_ext = {{(CONV_W-MAP_W){x_in[MAP_W-1]}}, x_in} <<< SH;
        if (x_ext[CONV_W-1]) begin
            mag_d = CONV_W'(-x_ext);
        end else begin
            mag_d = CONV_W'(x_ext);
        end
        prod     = PROD_W'(mag_q) * PROD_W'(SCALE_K);
        scaled_d = prod[CONV_F+CONV_W-1:CONV_F];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mag_q    <= '0;
            scaled_q <= '0;
        end else begin
            if (cap_mag) begin
                mag_q <= mag_d;
            end
            if (cap_scale) begin
                scaled_q <= scaled_d;
            end
        end
    end
endmodule

// File: rtl/kmap_divn.sv
// Restoring shift-subtract divider by a constant, one quotient bit per step.
module kmap_divn #(
    parameter int N_W = 32,
    parameter int unsigned DIV = 255
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [N_W-1:0] dividend,
    output logic [N_W-1:0] quotient,
    output logic           last
);
    localparam int R_W = $clog2(DIV);
    localparam int C_W = $clog2(N_W);
    localparam logic [R_W:0] DIV_C = (R_W+1)'(DIV);

    logic [N_W-1:0] dvd_q;
    logic [R_W-1:0] rem_q;
    logic [C_W-1:0] cnt_q;
    logic [R_W:0]   rem_sh;
    logic [R_W:0]   rem_sub;
    logic           ge;

    always_comb begin
        rem_sh  = {rem_q, dvd_q[N_W-1]};
        ge      = (rem_sh >= DIV_C);
        rem_sub = rem_sh - DIV_C;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            dvd_q <= dividend;
            rem_q <= '0;
            cnt_q <= '0;
        end else if (step) begin
            dvd_q <= {dvd_q[N_W-2:0], ge};
            rem_q <= ge ? rem_sub[R_W-1:0] : rem_sh[R_W-1:0];
            cnt_q <= cnt_q + C_W'(1);
        end
    end

    assign quotient = dvd_q;
    assign last     = step && (cnt_q == C_W'(N_W - 1));
endmodule

// File: rtl/kmap_keystream.sv
// On-demand chaotic keystream byte generator: controller and reduction datapath.
module kmap_keystream #(
    parameter int MAP_W   = 24,
    parameter int MAP_F   = 20,
    parameter int CONV_W  = 32,
    parameter int CONV_F  = 23,
    parameter int OUT_W   = 8,
    parameter int unsigned SCALE_K = 10_000_000,
    parameter int unsigned MOD_N   = 255,
    parameter int unsigned A_FX    = kmap_pkg::KMAP_A_DEF,
    parameter int unsigned B_FX    = kmap_pkg::KMAP_B_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_load,
    input  logic [MAP_W-1:0] key_x,
    input  logic [MAP_W-1:0] key_y,
    input  logic             start,
    output logic             done,
    output logic [OUT_W-1:0] byte_out
);
    import kmap_pkg::*;

    kmap_state_e state_q, state_d;

    logic signed [MAP_W-1:0] x_q, y_q;
    logic signed [MAP_W-1:0] x_nxt, y_nxt;
    logic [CONV_W-1:0]       scaled_d, scaled_q;
    logic [CONV_W-1:0]       quot;
    logic [CONV_W-1:0]       mulb_q;
    logic [CONV_W-1:0]       diff;
    logic                    div_last;
    logic                    accept;
    logic                    busy;
    logic                    done_q;
    logic [OUT_W-1:0]        byte_q;

    assign busy   = (state_q != ST_IDLE);
    assign accept = (state_q == ST_IDLE) && start && !key_load;
    assign diff   = scaled_q - mulb_q;

    kmap_step #(
        .W(MAP_W), .F(MAP_F), .A_FX(A_FX), .B_FX(B_FX)
    ) u_step (
        .x_cur(x_q), .y_cur(y_q), .x_nxt(x_nxt), .y_nxt(y_nxt)
    );

    kmap_scale #(
        .MAP_W(MAP_W), .MAP_F(MAP_F), .CONV_W(CONV_W),
        .CONV_F(CONV_F), .SCALE_K(SCALE_K)
    ) u_scale (
        .clk(clk), .rst_n(rst_n), .x_in(x_q),
        .cap_mag(state_q == ST_MAG), .cap_scale(state_q == ST_SCALE),
        .scaled_d(scaled_d), .scaled_q(scaled_q)
    );

    kmap_divn #(
        .N_W(CONV_W), .DIV(MOD_N)
    ) u_div (
        .clk(clk), .rst_n(rst_n),
        .load(state_q == ST_SCALE), .step(state_q == ST_DIV),
        .dividend(scaled_d), .quotient(quot), .last(div_last)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (key_load) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) state_d = ST_MAG;
                ST_MAG:   state_d = ST_SCALE;
                ST_SCALE: state_d = ST_DIV;
                ST_DIV:   if (div_last) state_d = ST_MULB;
                ST_MULB:  state_d = ST_SUB;
                ST_SUB:   state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Map registers, multiply-back, subtract and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            mulb_q <= '0;
            byte_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (key_load) begin
                x_q <= key_x;
                y_q <= key_y;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (accept) begin
                            x_q <= x_nxt;
                            y_q <= y_nxt;
                        end
                    end
                    ST_MULB: mulb_q <= quot * CONV_W'(MOD_N);
                    ST_SUB: begin
                        byte_q <= diff[OUT_W-1:0];
                        done_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign done     = done_q;
    assign byte_out = byte_q;
endmodule

// File: rtl/kmap_keystream_chk.sv
// Property checker bound to the keystream generator.
module kmap_keystream_chk #(
    parameter int OUT_W = 8,
    parameter int unsigned MOD_N = 255,
    parameter int LAT = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             key_load,
    input logic             busy,
    input logic             done,
    input logic [OUT_W-1:0] byte_out
);
    logic       armed;
    logic [6:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (key_load) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (start && !busy) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (done) begin
            armed <= 1'b0;
        end else if (armed && cnt != 7'h7f) begin
            cnt <= cnt + 7'd1;
        end
    end

    p_byte_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (byte_out < OUT_W'(MOD_N)));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (armed && cnt == 7'(LAT)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(byte_out));

    p_load_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> (!busy && !done));

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !key_load) |=> busy);
endmodule

bind kmap_keystream kmap_keystream_chk #(
    .OUT_W(OUT_W), .MOD_N(MOD_N), .LAT(36)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .key_load(key_load),
    .busy(busy), .done(done), .byte_out(byte_out)
);

// File: tb/kmap_keystream_tb.sv
module kmap_keystream_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_load = 1'b0;
    logic [23:0] key_x = '0;
    logic [23:0] key_y = '0;
    logic        start = 1'b0;
    logic        done;
    logic [7:0]  byte_out;

    int checks = 0;
    int failures = 0;
    longint mx = 0;
    longint my = 0;

    always #2 clk = ~clk;

    kmap_keystream u_dut (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_x(key_x),
        .key_y(key_y), .start(start), .done(done), .byte_out(byte_out)
    );

    // Hand-derived bytes for the all-zero key, iterations 1..3.
    localparam logic [7:0] VEC_EXP [3] = '{8'd175, 8'd66, 8'd31};

    localparam longint A_M = 1468006;
    localparam longint B_M = 314572;
    localparam longint ONE_M = 1048576;

    function automatic longint wrap24(longint v);
        longint r;
        r = v & 64'hFF_FFFF;
        if (r >= 64'h80_0000) r = r - 64'h100_0000;
        return r;
    endfunction

    function automatic longint sx24(logic [23:0] v);
        return wrap24(longint'(v));
    endfunction

    // R2 reference step
    task automatic model_step();
        longint xx, ax, nx, ny;
        xx = wrap24((mx * mx) >>> 20);
        ax = wrap24((A_M * xx) >>> 20);
        nx = wrap24(ONE_M - ax + my);
        ny = wrap24((B_M * mx) >>> 20);
        mx = nx;
        my = ny;
    endtask

    // R3 reference byte
    function automatic longint model_byte(longint x);
        longint m, s;
        m = x * 8;
        if (m < 0) m = -m;
        s = (m * 10000000) >>> 23;
        return s % 255;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_key(logic [23:0] kx, logic [23:0] ky);
        @(negedge clk);
        key_load = 1'b1;
        key_x = kx;
        key_y = ky;
        @(negedge clk);
        key_load = 1'b0;
        mx = sx24(kx);
        my = sx24(ky);
    endtask

    task automatic run_one(output logic [7:0] b, output int lat);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        b = byte_out;
        model_step();
    endtask

    task automatic expect_quiet(int n, string req);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk(req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [7:0] seq_a [24];
        int lat;
        int ndiff;

        repeat (3) @(negedge clk);
        chk("R1 done at reset", longint'(done), 0);
        chk("R1 byte at reset", longint'(byte_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: first request from the reset state (x=y=0).
        run_one(b, lat);
        chk("R1 first byte after reset", longint'(b), 175);

        // Table walk: zero key, iterations 1..3 (R2, R3; entry 2 is a negative state).
        for (int i = 0; i < 3; i++) begin
            load_key(24'h0, 24'h0);
            for (int k = 0; k <= i; k++) begin
                run_one(b, lat);
                chk("R4 latency", lat, 36);
            end
            chk("R2/R3 table byte", longint'(b), longint'(VEC_EXP[i]));
        end

        // R8/R2/R3: consecutive iterates against the model from a nonzero key.
        load_key(24'h0A3D71, 24'h012345);
        for (int i = 0; i < 24; i++) begin
            run_one(b, lat);
            seq_a[i] = b;
            chk("R8 sequence byte", longint'(b), model_byte(mx));
            chk("R3 byte range", longint'(b < 8'd255), 1);
        end

        // R7: one-LSB change in key_x.
        load_key(24'h0A3D72, 24'h012345);
        ndiff = 0;
        for (int i = 0; i < 24; i++) begin
            run_one(b, lat);
            chk("R7 perturbed byte", longint'(b), model_byte(mx));
            if (b != seq_a[i]) ndiff++;
        end
        chk("R7 sequences differ", longint'(ndiff > 0), 1);

        // R5: request during a conversion is ignored.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        model_step();
        chk("R5 latency unchanged", lat, 36);
        chk("R5 byte", longint'(byte_out), model_byte(mx));
        expect_quiet(45, "R5 no second done");
        run_one(b, lat);
        chk("R5 single iteration advanced", longint'(b), model_byte(mx));

        // R6: key load aborts a conversion.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        load_key(24'hF5C28F, 24'h00A000);
        expect_quiet(50, "R6 no done after abort");
        run_one(b, lat);
        chk("R6 first byte after load", longint'(b), model_byte(mx));
        chk("R6 latency", lat, 36);

        // R9: load and request in the same cycle.
        @(negedge clk);
        key_load = 1'b1;
        start = 1'b1;
        key_x = 24'h03_0000;
        key_y = 24'hFF_8000;
        @(negedge clk);
        key_load = 1'b0;
        start = 1'b0;
        mx = sx24(24'h03_0000);
        my = sx24(24'hFF_8000);
        expect_quiet(45, "R9 request dropped");
        run_one(b, lat);
        chk("R9 first byte after load", longint'(b), model_byte(mx));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule